// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Controller

This block sits between a processor-side byte port and a slower block-oriented memory. Each request carries an address, a read/write flag and, for stores, one data byte. The address is cut into a tag in the upper bits, a set index in the middle and a byte offset within the block in the low bits. All ways of the indexed set are compared at once. A request that finds a valid line with the same tag completes in the cycle it is presented.

A request that misses holds the processor port while a small state machine handles it. The state machine picks a line in the set. An empty line is taken first. If every line is full, it takes the line whose last use is oldest. If that line holds modified data, the whole block is written out to memory. The block that holds the requested address is then read in. The request then completes on the freshly filled line. Stores never go straight to memory. A store marks its line as modified, and a store miss first brings the block into the cache. Two counters report how many requests hit and how many missed.

Sets, ways, block size and address width are parameters. The capacity is sets × ways × block bytes. The tag, valid and dirty state is held on top of that capacity.

Top module: `assoc_wb_cache`

## Requirements
- R1: The address is read as tag (top ADDR_W−SET_W−OFF_W bits), set index (next SET_W bits) and byte offset (low OFF_W bits). Two addresses that differ only in the offset share one block.
- R2: A request hits when a valid line in its set has a matching tag. `req_done` is then high in the same cycle the request is presented, with the addressed byte on `req_rdata` for a read.
- R3: A miss reads the whole block from memory at the block-aligned address (offset bits zero) and returns the requested byte from the filled line. `req_done` rises in the cycle after the read is acknowledged.
- R4: When every way of the set is valid, the miss replaces the way whose last completed access is oldest.
- R5: When some ways are invalid, the lowest-numbered invalid way is filled, and no write-back occurs.
- R6: A store hit changes only the cached byte and marks the line dirty. No memory write happens for it.
- R7: A dirty victim is written to memory in full, at its own block address, before the new block is requested. The written data includes every earlier store to that block.
- R8: A store miss first fills the block. The byte is then written into the cached copy, which leaves the line dirty, and a later read returns the stored value.
- R9: During write-back and fill, `req_done` stays low. `mem_rd_req` and `mem_wr_req` are never high together.
- R10: Each completed request adds exactly one to either `hit_count` (a hit) or `miss_count` (a miss). The counters are otherwise unchanged.
- R11: After reset all lines are invalid and clean. `req_done`, both memory requests and both counters are zero.
- R12: With 4 sets, 1 way, 2-byte blocks and 4-bit addresses, the reads 0, 1, 13, 8, 0 give miss, hit, miss, miss, miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_done` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Store byte |
| req_done | output | 1 | Request completes this cycle |
| req_rdata | output | 8 | Load byte, valid with `req_done` |
| mem_rd_req | output | 1 | Block read request, held until acknowledge |
| mem_wr_req | output | 1 | Block write request, held until acknowledge |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_wdata | output | 8·BLOCK_BYTES | Block written back |
| mem_rdata | input | 8·BLOCK_BYTES | Block returned, sampled with `mem_ack` |
| mem_ack | input | 1 | Memory transfer complete |
| hit_count | output | CNT_W | Completed hits |
| miss_count | output | CNT_W | Completed misses |

## Verification
A hit is due in the cycle its request is driven. A clean miss is due one cycle after the fill acknowledge. With the bench memory answering on the second cycle of a request, that makes 3 cycles for a clean miss and 6 for a dirty one. The bench predicts which case applies from its own model of tags, validity, dirtiness and last-use times. It counts cycles from the request to `req_done` and compares the count with that prediction. Data, the memory transfer addresses and the counter deltas are sampled half a cycle away from the clock edge. The counters are read after the commit edge.

// File: rtl/assoc_wb_cache.sv
module assoc_wb_cache #(
  parameter int ADDR_W      = 8,
  parameter int SETS        = 4,
  parameter int WAYS        = 2,
  parameter int BLOCK_BYTES = 4,
  parameter int CNT_W       = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [7:0]                 req_wdata,
  output logic                       req_done,
  output logic [7:0]                 req_rdata,
  output logic                       mem_rd_req,
  output logic                       mem_wr_req,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [BLOCK_BYTES*8-1:0]   mem_wdata,
  input  logic [BLOCK_BYTES*8-1:0]   mem_rdata,
  input  logic                       mem_ack,
  output logic [CNT_W-1:0]           hit_count,
  output logic [CNT_W-1:0]           miss_count
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int BLK_W = BLOCK_BYTES * 8;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int LINES = SETS * WAYS;
  localparam int LI_W  = $clog2(LINES);

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_DONE} state_t;

  function automatic logic [LI_W-1:0] li(input logic [SET_W-1:0] s, input logic [WAY_W-1:0] w);
    return LI_W'(32'(s) * WAYS + 32'(w));
  endfunction

  state_t              st;
  logic [ADDR_W-1:0]   a_q;
  logic                w_q;
  logic [7:0]          d_q;
  logic [WAY_W-1:0]    v_q;

  logic [BLK_W-1:0]    data_q  [LINES];
  logic [TAG_W-1:0]    tag_q   [LINES];
  logic [WAY_W-1:0]    age_q   [LINES];
  logic [LINES-1:0]    valid_q;
  logic [LINES-1:0]    dirty_q;

  logic [ADDR_W-1:0]   cur_addr;
  logic [OFF_W-1:0]    cur_off;
  logic [SET_W-1:0]    cur_set;
  logic [TAG_W-1:0]    cur_tag;
  logic                hit;
  logic [WAY_W-1:0]    hit_way;
  logic [WAY_W-1:0]    victim;
  logic                vic_found;
  logic [WAY_W-1:0]    sel_way;
  logic [LI_W-1:0]     sel_l;
  logic [LI_W-1:0]     vic_l;
  logic [LI_W-1:0]     new_l;
  logic                commit_hit;
  logic                wr_now;
  logic [7:0]          wd_now;

  assign cur_addr = (st == S_IDLE) ? req_addr : a_q;
  assign cur_off  = cur_addr[OFF_W-1:0];
  assign cur_set  = cur_addr[OFF_W +: SET_W];
  assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit && valid_q[li(cur_set, WAY_W'(w))] && tag_q[li(cur_set, WAY_W'(w))] == cur_tag) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    vic_found = 1'b0;
    victim    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vic_found && !valid_q[li(cur_set, WAY_W'(w))]) begin
        vic_found = 1'b1;
        victim    = WAY_W'(w);
      end
    end
    if (!vic_found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[li(cur_set, WAY_W'(w))] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
      end
    end
  end

  assign sel_way    = (st == S_DONE) ? v_q : hit_way;
  assign sel_l      = li(cur_set, sel_way);
  assign vic_l      = li(cur_set, v_q);
  assign new_l      = li(cur_set, victim);
  assign commit_hit = (st == S_IDLE) && req_valid && hit;
  assign req_done   = commit_hit || (st == S_DONE);
  assign wr_now     = (st == S_IDLE) ? req_write : w_q;
  assign wd_now     = (st == S_IDLE) ? req_wdata : d_q;
  assign req_rdata  = data_q[sel_l][{cur_off, 3'b000} +: 8];

  assign mem_wr_req = (st == S_WB);
  assign mem_rd_req = (st == S_FILL);
  assign mem_addr   = (st == S_WB) ? {tag_q[vic_l], cur_set, OFF_W'(0)}
                                   : {cur_tag, cur_set, OFF_W'(0)};
  assign mem_wdata  = data_q[vic_l];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      a_q <= '0;
      w_q <= 1'b0;
      d_q <= '0;
      v_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid && !hit) begin
          a_q <= req_addr;
          w_q <= req_write;
          d_q <= req_wdata;
          v_q <= victim;
          st  <= (valid_q[new_l] && dirty_q[new_l]) ? S_WB : S_FILL;
        end
        S_WB:   if (mem_ack) st <= S_FILL;
        S_FILL: if (mem_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[li(SET_W'(s), WAY_W'(w))] <= WAY_W'(w);
    end else begin
      if (st == S_FILL && mem_ack) begin
        valid_q[vic_l] <= 1'b1;
        dirty_q[vic_l] <= 1'b0;
      end
      if (req_done) begin
        if (wr_now) dirty_q[sel_l] <= 1'b1;
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == sel_way)
            age_q[li(cur_set, WAY_W'(w))] <= '0;
          else if (age_q[li(cur_set, WAY_W'(w))] < age_q[sel_l])
            age_q[li(cur_set, WAY_W'(w))] <= age_q[li(cur_set, WAY_W'(w))] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_ack) begin
      data_q[vic_l] <= mem_rdata;
      tag_q[vic_l]  <= cur_tag;
    end
    if (req_done && wr_now) data_q[sel_l][{cur_off, 3'b000} +: 8] <= wd_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (commit_hit)     hit_count  <= hit_count + 1'b1;
      if (st == S_DONE)   miss_count <= miss_count + 1'b1;
    end
  end
endmodule

// File: rtl/assoc_wb_cache_chk.sv
module assoc_wb_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 2,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_done,
  input logic              mem_rd_req,
  input logic              mem_wr_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  a_r9_single_mem_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  a_r9_stall_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wr_req) |-> !req_done);

  a_r3_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wr_req) |-> (mem_addr[OFF_W-1:0] == '0));

  a_r3_done_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_ack) |=> req_done);

  a_r7_wb_before_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_ack) |=> mem_rd_req);

  a_r10_one_count: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> (CNT_W'(hit_count + miss_count) == CNT_W'($past(hit_count) + $past(miss_count) + 1'b1)));

  a_r10_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    !req_done |=> ($stable(hit_count) && $stable(miss_count)));
endmodule

bind assoc_wb_cache assoc_wb_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_done(req_done), .mem_rd_req(mem_rd_req),
  .mem_wr_req(mem_wr_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/sim_assoc_wb_cache.sv
`timescale 1ns/1ps
module sim_assoc_wb_cache;
  localparam int NS = 4, NE = 2, NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_addr = 0, req_wdata = 0;
  logic        req_done;
  logic [7:0]  req_rdata;
  logic        mem_rd_req, mem_wr_req, mem_ack = 0;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;
  logic [15:0] hit_count, miss_count;

  assoc_wb_cache u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .hit_count(hit_count), .miss_count(miss_count));

  logic        r1_valid = 0;
  logic [3:0]  r1_addr = 0;
  logic        r1_done, r1_rd, r1_wr, r1_ack = 0;
  logic [7:0]  r1_rdata;
  logic [3:0]  r1_maddr;
  logic [15:0] r1_wdata, r1_mrdata = 0;
  logic [15:0] r1_hits, r1_misses;

  assoc_wb_cache #(.ADDR_W(4), .SETS(4), .WAYS(1), .BLOCK_BYTES(2), .CNT_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(r1_valid), .req_write(1'b0),
    .req_addr(r1_addr), .req_wdata(8'h00), .req_done(r1_done), .req_rdata(r1_rdata),
    .mem_rd_req(r1_rd), .mem_wr_req(r1_wr), .mem_addr(r1_maddr),
    .mem_wdata(r1_wdata), .mem_rdata(r1_mrdata), .mem_ack(r1_ack),
    .hit_count(r1_hits), .miss_count(r1_misses));

  int n_checks = 0, n_fail = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] lmem [256];
  bit         mv [NS*NE];
  bit         md [NS*NE];
  logic [3:0] mt [NS*NE];
  int         mstamp [NS*NE];
  int         tick = 0;
  int         wr_seen = 0, rd_seen = 0, m_cnt = 0;
  logic [7:0] exp_wb_addr, exp_fill_addr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial forever @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0; m_cnt = 0;
    end else if (mem_rd_req || mem_wr_req) begin
      m_cnt++;
      if (m_cnt == 2) begin
        mem_ack = 1;
        if (mem_wr_req) begin
          wr_seen++;
          chk(mem_addr == exp_wb_addr, "R4 R7 write-back address", mem_addr, exp_wb_addr);
          for (int i = 0; i < NB; i++) begin
            chk(mem_wdata[i*8 +: 8] == ref_mem[mem_addr + i], "R7 write-back data",
                mem_wdata[i*8 +: 8], ref_mem[mem_addr + i]);
            lmem[mem_addr + i] = mem_wdata[i*8 +: 8];
          end
        end else begin
          rd_seen++;
          chk(mem_addr == exp_fill_addr, "R3 fill address", mem_addr, exp_fill_addr);
          for (int i = 0; i < NB; i++) mem_rdata[i*8 +: 8] = lmem[mem_addr + i];
        end
      end
    end
  end

  initial forever @(negedge clk) begin
    if (r1_ack) r1_ack = 0;
    else if (r1_rd) begin
      r1_ack = 1;
      r1_mrdata = {4'(r1_maddr + 1) * 8'd7, r1_maddr * 8'd7};
    end
  end

  task automatic do_req(input bit wr, input logic [7:0] addr, input logic [7:0] wd);
    int s, off, hw, v, vl, lat, exp_lat, ws0, rs0;
    logic [3:0] tg;
    bit dirty_v;
    logic [15:0] h0, m0;
    logic [7:0] got;
    s = int'(addr[3:2]); tg = addr[7:4]; off = int'(addr[1:0]);
    hw = -1;
    for (int w = 0; w < NE; w++) if (mv[s*NE+w] && mt[s*NE+w] == tg) hw = w;
    v = -1;
    if (hw < 0) begin
      for (int w = NE-1; w >= 0; w--) if (!mv[s*NE+w]) v = w;
      if (v < 0) begin
        v = 0;
        for (int w = 1; w < NE; w++) if (mstamp[s*NE+w] < mstamp[s*NE+v]) v = w;
      end
      vl = s*NE + v;
      dirty_v = mv[vl] && md[vl];
      exp_wb_addr = {mt[vl], 2'(s), 2'b00};
      exp_fill_addr = {tg, 2'(s), 2'b00};
      exp_lat = dirty_v ? 6 : 3;
    end else begin
      vl = s*NE + hw;
      dirty_v = 0;
      exp_lat = 0;
    end
    ws0 = wr_seen; rs0 = rd_seen; h0 = hit_count; m0 = miss_count;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd;
    lat = 0;
    forever begin
      #1;
      if (req_done || lat > 60) break;
      @(negedge clk);
      lat++;
    end
    got = req_rdata;
    chk(lat == exp_lat, hw >= 0 ? "R2 hit latency" : (dirty_v ? "R7 dirty miss latency" : "R3 R5 clean miss latency"), lat, exp_lat);
    if (!wr) chk(got == ref_mem[addr], hw >= 0 ? "R2 R1 hit data" : "R3 miss data", got, ref_mem[addr]);
    @(posedge clk); #1;
    chk(wr_seen - ws0 == int'(dirty_v), wr && hw >= 0 ? "R6 no memory write on store hit" : "R7 write-back count",
        wr_seen - ws0, int'(dirty_v));
    chk(rd_seen - rs0 == int'(hw < 0), wr && hw < 0 ? "R8 store miss fills block" : "R3 fill count",
        rd_seen - rs0, int'(hw < 0));
    chk(hit_count == h0 + 16'(hw >= 0) && miss_count == m0 + 16'(hw < 0), "R10 counters",
        int'(hit_count + miss_count), int'(h0 + m0 + 1));
    if (hw < 0) begin
      mv[vl] = 1; md[vl] = 0; mt[vl] = tg;
    end
    tick++;
    mstamp[vl] = tick;
    if (wr) begin
      ref_mem[addr] = wd;
      md[vl] = 1;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_req1(input logic [3:0] addr, input bit exp_miss);
    logic [15:0] m0;
    m0 = r1_misses;
    @(negedge clk);
    r1_valid = 1; r1_addr = addr;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (r1_done) break;
      @(negedge clk);
    end
    chk(r1_rdata == 8'(addr * 8'd7), "R12 read data", r1_rdata, addr * 7);
    @(posedge clk); #1;
    chk(r1_misses - m0 == 16'(exp_miss), "R12 miss/hit pattern", int'(r1_misses - m0), int'(exp_miss));
    @(negedge clk);
    r1_valid = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ref_mem[i] = 8'(i) ^ 8'h5A;
      lmem[i] = 8'(i) ^ 8'h5A;
    end
    for (int i = 0; i < NS*NE; i++) begin
      mv[i] = 0; md[i] = 0; mt[i] = 0; mstamp[i] = 0;
    end
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!req_done && !mem_rd_req && !mem_wr_req, "R11 idle outputs", int'(req_done), 0);
    chk(hit_count == 0 && miss_count == 0, "R11 counters zero", int'(hit_count + miss_count), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!req_done && !mem_rd_req && !mem_wr_req, "R11 idle after release", int'(mem_rd_req), 0);

    do_req(0, 8'h00, 0);
    do_req(0, 8'h03, 0);
    do_req(0, 8'h10, 0);
    do_req(1, 8'h11, 8'hC3);
    do_req(0, 8'h00, 0);
    do_req(0, 8'h20, 0);
    do_req(0, 8'h11, 0);
    do_req(1, 8'h34, 8'h9E);
    do_req(0, 8'h34, 0);
    do_req(1, 8'h35, 8'h11);
    do_req(0, 8'h44, 0);
    do_req(0, 8'h54, 0);
    do_req(0, 8'h35, 0);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, d;
      bit w;
      a = 8'($urandom % 64);
      d = 8'($urandom);
      w = bit'($urandom % 2);
      do_req(w, a, d);
    end

    do_req1(4'd0, 1);
    do_req1(4'd1, 0);
    do_req1(4'd13, 1);
    do_req1(4'd8, 1);
    do_req1(4'd0, 1);

    finish_run();
  end
endmodule